// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the instruction fetch unit. Each cycle that fetch presents a program counter, the block looks it up in two structures at once. One is a table of 2-bit saturating counters, indexed by low PC bits and without tags, that votes taken or not-taken. The other is a small direct-mapped cache of branch targets, tagged with the upper PC bits, that supplies a jump address only when the stored branch address matches the fetch address. One cycle later the block returns the direction and hit flags and the next fetch address. That address is the cached target when the vote is taken and the tag hits, and the sequential address PC+4 otherwise.

When a branch resolves later in the pipeline, the resolve port reports its address, its real direction, its real target and the next address that was predicted for it. The block moves the counter one step toward the real outcome. On a taken branch it writes the target cache entry. One cycle later it raises a mispredict flag and gives the correct restart address whenever the predicted next address was wrong, so that the pipeline can squash the wrong-path instructions and refetch.

Sharing of counters between branches whose low PC bits collide costs accuracy but never produces a wrong address, because targets are only taken from a tag-matched entry.

Top module: `branch_predictor`

## Requirements
- R1: After synchronous reset, pred_valid and res_mispredict are 0 and every counter holds weakly not-taken (01), so a fetch predicts not-taken with next address PC+4, and a single taken resolve is enough to make the same PC predict taken.
- R2: pred_valid is 1 in the cycle after a cycle with fetch_valid=1, and 0 in the cycle after fetch_valid=0; the prediction fields belong to that earlier fetch.
- R3: The counter encoding is 00 and 01 for not-taken and 10 and 11 for taken. A taken resolve increments it, saturating at 11, and a not-taken resolve decrements it, saturating at 00. pred_taken is the upper counter bit.
- R4: From the strongly taken state, one not-taken resolve leaves the prediction taken. The prediction turns to not-taken only after a second one.
- R5: The counter index is PC bits [2 +: log2(HIST_DEPTH)], with no tag. Two PCs that agree in those bits share one counter.
- R6: pred_hit is 1 only if the target entry at index PC bits [2 +: log2(TGT_DEPTH)] is valid and its stored upper PC bits equal those of the fetch PC. A same-index branch with a different tag does not hit.
- R7: Only taken resolves write the target cache, which overwrites the indexed entry. A not-taken resolve leaves the entry, and its hit, in place.
- R8: pred_next_pc equals the cached target when pred_taken and pred_hit are both 1, and the fetch PC plus 4 otherwise.
- R9: One cycle after a resolve, res_mispredict is 1 exactly when the real next address differs from res_pred_next. The real next address is res_target if the branch was taken and res_pc+4 if it was not. While res_mispredict is 1, res_redirect_pc carries that real next address. With no resolve, res_mispredict is 0.
- R10: A fetch and a resolve to the same entries in the same cycle return the state from before the update. The update is visible to the next fetch.
- R11: Reset clears every target cache valid bit, so no fetch hits until a taken branch is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch address is presented |
| fetch_pc | input | PC_W | Fetch address, word aligned |
| pred_valid | output | 1 | Prediction for last cycle's fetch is present |
| pred_taken | output | 1 | Counter votes taken |
| pred_hit | output | 1 | Target cache tag matched |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | A resolved branch is reported |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Real direction |
| res_target | input | PC_W | Real taken target |
| res_pred_next | input | PC_W | Next address that was predicted for this branch |
| res_mispredict | output | 1 | Prediction was wrong; flush and redirect |
| res_redirect_pc | output | PC_W | Correct restart address |

## Verification
The properties assume that every address and target on the ports is word aligned and that fetch and resolve inputs are held stable around the sampling edge. They also assume that res_pred_next is an arbitrary address supplied by the pipeline. The block itself does not enforce any relation between res_pred_next and its own earlier output. The stimulus draws only word-aligned addresses and targets. It mixes in deliberate aliases that share a counter and a cache index but differ in tag. It supplies res_pred_next both as the correct next address and as a wrong one, so that the mispredict and redirect properties are exercised in both directions.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_INIT = CTR_WNT;

  // one saturating step toward the observed outcome
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
      default: nxt = CTR_INIT;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_vote(input ctr_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table
  import bp_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_taken,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_taken
);

  ctr_e ctr_mem [DEPTH];
  ctr_e rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_mem[i] <= CTR_INIT;
      rd_q <= CTR_INIT;
    end else begin
      if (wr_en) ctr_mem[wr_idx] <= ctr_step(ctr_mem[wr_idx], wr_taken);
      if (rd_en) rd_q <= ctr_mem[rd_idx];
    end
  end

  assign rd_taken = ctr_vote(rd_q);

endmodule

// File: rtl/bp_target_cache.sv
module bp_target_cache #(
  parameter int DEPTH = 64,
  parameter int TAG_W = 24,
  parameter int PC_W  = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IW-1:0]    rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_target,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_target
);

  // tag and target arrays: no reset, one write port, synchronous read
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [PC_W-1:0]  tgt_mem [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_target;
    end
    if (rd_en) begin
      rd_tag    <= tag_mem[rd_idx];
      rd_target <= tgt_mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) vld[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= vld[rd_idx];
    end
  end

endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic [PC_W-1:0] res_pred_next,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc
);

  logic [PC_W-1:0] actual_next;

  assign actual_next = res_taken ? res_target : res_pc + PC_W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      mispredict  <= 1'b0;
      redirect_pc <= '0;
    end else begin
      mispredict  <= res_valid && (actual_next != res_pred_next);
      redirect_pc <= actual_next;
    end
  end

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
  parameter int PC_W       = 32,
  parameter int HIST_DEPTH = 4096,
  parameter int TGT_DEPTH  = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic [PC_W-1:0] res_pred_next,
  output logic            res_mispredict,
  output logic [PC_W-1:0] res_redirect_pc
);

  localparam int IDX_LSB = 2;
  localparam int HIST_IW = $clog2(HIST_DEPTH);
  localparam int TGT_IW  = $clog2(TGT_DEPTH);
  localparam int TAG_W   = PC_W - IDX_LSB - TGT_IW;

  logic            pv_q;
  logic [PC_W-1:0] fpc_q;
  logic            h_taken;
  logic            c_valid;
  logic [TAG_W-1:0] c_tag;
  logic [PC_W-1:0] c_target;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv_q  <= 1'b0;
      fpc_q <= '0;
    end else begin
      pv_q  <= fetch_valid;
      if (fetch_valid) fpc_q <= fetch_pc;
    end
  end

  bp_hist_table #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (fetch_valid),
    .rd_idx   (fetch_pc[IDX_LSB +: HIST_IW]),
    .rd_taken (h_taken),
    .wr_en    (res_valid),
    .wr_idx   (res_pc[IDX_LSB +: HIST_IW]),
    .wr_taken (res_taken)
  );

  bp_target_cache #(.DEPTH(TGT_DEPTH), .TAG_W(TAG_W), .PC_W(PC_W)) u_tgt (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (fetch_valid),
    .rd_idx    (fetch_pc[IDX_LSB +: TGT_IW]),
    .rd_valid  (c_valid),
    .rd_tag    (c_tag),
    .rd_target (c_target),
    .wr_en     (res_valid && res_taken),
    .wr_idx    (res_pc[IDX_LSB +: TGT_IW]),
    .wr_tag    (res_pc[PC_W-1 -: TAG_W]),
    .wr_target (res_target)
  );

  bp_resolve #(.PC_W(PC_W)) u_res (
    .clk           (clk),
    .rst           (rst),
    .res_valid     (res_valid),
    .res_pc        (res_pc),
    .res_taken     (res_taken),
    .res_target    (res_target),
    .res_pred_next (res_pred_next),
    .mispredict    (res_mispredict),
    .redirect_pc   (res_redirect_pc)
  );

  assign pred_valid   = pv_q;
  assign pred_taken   = pv_q && h_taken;
  assign pred_hit     = pv_q && c_valid && (c_tag == fpc_q[PC_W-1 -: TAG_W]);
  assign pred_next_pc = (pred_taken && pred_hit) ? c_target : fpc_q + PC_W'(4);

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_valid,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            res_valid,
  input logic [PC_W-1:0] res_pc,
  input logic            res_taken,
  input logic [PC_W-1:0] res_target,
  input logic [PC_W-1:0] res_pred_next,
  input logic            res_mispredict,
  input logic [PC_W-1:0] res_redirect_pc
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pred_valid && !res_mispredict));

  assert_pred_follows_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid);

  assert_pred_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_valid);

  assert_seq_next_R8: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_taken) |-> (pred_next_pc == $past(fetch_pc) + PC_W'(4)));

  assert_redirect_R9: assert property (@(posedge clk) disable iff (rst)
    res_mispredict |-> (res_redirect_pc ==
      ($past(res_taken) ? $past(res_target) : $past(res_pc) + PC_W'(4))));

  assert_no_false_flush_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && (res_pred_next == (res_taken ? res_target : res_pc + PC_W'(4))))
      |=> !res_mispredict);

  assert_flush_needs_resolve_R9: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> !res_mispredict);

endmodule

bind branch_predictor bp_checker #(.PC_W(PC_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .fetch_valid     (fetch_valid),
  .fetch_pc        (fetch_pc),
  .pred_valid      (pred_valid),
  .pred_taken      (pred_taken),
  .pred_next_pc    (pred_next_pc),
  .res_valid       (res_valid),
  .res_pc          (res_pc),
  .res_taken       (res_taken),
  .res_target      (res_target),
  .res_pred_next   (res_pred_next),
  .res_mispredict  (res_mispredict),
  .res_redirect_pc (res_redirect_pc)
);

// File: tb/branch_predictor_tb.sv
module branch_predictor_tb;

  localparam int PW = 32;
  localparam int HD = 4096;
  localparam int TD = 64;
  localparam int TB = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fetch_valid = 1'b0;
  logic [PW-1:0] fetch_pc = '0;
  logic          pred_valid, pred_taken, pred_hit;
  logic [PW-1:0] pred_next_pc;
  logic          res_valid = 1'b0;
  logic [PW-1:0] res_pc = '0;
  logic          res_taken = 1'b0;
  logic [PW-1:0] res_target = '0;
  logic [PW-1:0] res_pred_next = '0;
  logic          res_mispredict;
  logic [PW-1:0] res_redirect_pc;

  always #4 clk = ~clk;

  branch_predictor #(.PC_W(PW), .HIST_DEPTH(HD), .TGT_DEPTH(TD)) u_dut (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hit(pred_hit),
    .pred_next_pc(pred_next_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_pred_next(res_pred_next),
    .res_mispredict(res_mispredict), .res_redirect_pc(res_redirect_pc)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string rq, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // behavioural reference: counters and target entries keyed by index
  int            m_cnt [int];
  logic [PW-1:0] m_tag [int];
  logic [PW-1:0] m_tgt [int];
  logic          started = 1'b0;
  logic          e_pv, e_pt, e_hit, e_mis;
  logic [PW-1:0] e_next, e_red;

  always @(posedge clk) begin
    int hi, ti, c;
    logic [PW-1:0] tg, act;
    if (rst) begin
      m_cnt.delete(); m_tag.delete(); m_tgt.delete();
      e_pv = 1'b0; e_mis = 1'b0;
    end else begin
      e_pv = fetch_valid;
      if (fetch_valid) begin
        hi = int'((fetch_pc >> 2) % HD);
        ti = int'((fetch_pc >> 2) % TD);
        tg = fetch_pc >> (2 + TB);
        c  = m_cnt.exists(hi) ? m_cnt[hi] : 1;
        e_pt  = (c >= 2);
        e_hit = m_tag.exists(ti) && (m_tag[ti] == tg);
        e_next = (e_pt && e_hit) ? m_tgt[ti] : fetch_pc + 4;
      end
      e_mis = 1'b0;
      if (res_valid) begin
        act   = res_taken ? res_target : res_pc + 4;
        e_mis = (act != res_pred_next);
        e_red = act;
        hi = int'((res_pc >> 2) % HD);
        ti = int'((res_pc >> 2) % TD);
        c  = m_cnt.exists(hi) ? m_cnt[hi] : 1;
        c  = res_taken ? ((c == 3) ? 3 : c + 1) : ((c == 0) ? 0 : c - 1);
        m_cnt[hi] = c;
        if (res_taken) begin
          m_tag[ti] = res_pc >> (2 + TB);
          m_tgt[ti] = res_target;
        end
      end
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R2", PW'(pred_valid), PW'(e_pv));
      if (e_pv) begin
        chk("R3", PW'(pred_taken), PW'(e_pt));
        chk("R6", PW'(pred_hit), PW'(e_hit));
        chk("R8", pred_next_pc, e_next);
      end
      chk("R9", PW'(res_mispredict), PW'(e_mis));
      if (e_mis) chk("R9", res_redirect_pc, e_red);
    end
  end

  task automatic cyc(input logic fv, input logic [PW-1:0] fpc,
                     input logic rv, input logic [PW-1:0] rpc, input logic rt,
                     input logic [PW-1:0] rtg, input logic [PW-1:0] rpn);
    fetch_valid = fv; fetch_pc = fpc;
    res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtg; res_pred_next = rpn;
    @(posedge clk);
    @(negedge clk);
    fetch_valid = 1'b0; res_valid = 1'b0;
  endtask

  task automatic fetch(input logic [PW-1:0] pc);
    cyc(1'b1, pc, 1'b0, '0, 1'b0, '0, '0);
  endtask

  task automatic resolve(input logic [PW-1:0] pc, input logic t,
                         input logic [PW-1:0] tgt, input logic [PW-1:0] pn);
    cyc(1'b0, '0, 1'b1, pc, t, tgt, pn);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", PW'(pred_valid), 0);
    chk("R1", PW'(res_mispredict), 0);

    // R1: fresh counter is weakly not-taken
    fetch(32'h100);
    chk("R1", PW'(pred_taken), 0);
    chk("R1", PW'(pred_hit), 0);
    chk("R1", pred_next_pc, 32'h104);

    // R9: taken branch that was predicted sequential
    resolve(32'h100, 1'b1, 32'h200, 32'h104);
    chk("R9", PW'(res_mispredict), 1);
    chk("R9", res_redirect_pc, 32'h200);

    // R1/R3/R8: one taken step flips weakly not-taken to taken
    fetch(32'h100);
    chk("R1", PW'(pred_taken), 1);
    chk("R8", pred_next_pc, 32'h200);

    resolve(32'h100, 1'b1, 32'h200, 32'h200);
    chk("R9", PW'(res_mispredict), 0);
    resolve(32'h100, 1'b0, 32'h200, 32'h200);
    chk("R9", PW'(res_mispredict), 1);
    chk("R9", res_redirect_pc, 32'h104);

    // R4: one miss from strong taken keeps the vote
    fetch(32'h100);
    chk("R4", PW'(pred_taken), 1);
    resolve(32'h100, 1'b0, 32'h200, 32'h200);
    fetch(32'h100);
    chk("R4", PW'(pred_taken), 0);
    chk("R7", PW'(pred_hit), 1);
    chk("R8", pred_next_pc, 32'h104);

    // R5: alias shares the counter; R6: different tag evicts and misses
    resolve(32'h4100, 1'b1, 32'h500, 32'h4104);
    resolve(32'h4100, 1'b1, 32'h500, 32'h500);
    fetch(32'h100);
    chk("R5", PW'(pred_taken), 1);
    chk("R6", PW'(pred_hit), 0);
    chk("R8", pred_next_pc, 32'h104);
    fetch(32'h4100);
    chk("R6", PW'(pred_hit), 1);
    chk("R8", pred_next_pc, 32'h500);

    // R10: same-cycle lookup and update sees old state
    cyc(1'b1, 32'h300, 1'b1, 32'h300, 1'b1, 32'h800, 32'h304);
    chk("R10", PW'(pred_taken), 0);
    chk("R10", PW'(pred_hit), 0);
    fetch(32'h300);
    chk("R10", PW'(pred_taken), 1);
    chk("R10", pred_next_pc, 32'h800);

    // R11: reset drops all cached targets
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fetch(32'h300);
    chk("R11", PW'(pred_hit), 0);
    chk("R11", pred_next_pc, 32'h304);

    // mixed traffic over aliasing addresses, compared by the model
    for (int i = 0; i < 4000; i++) begin
      logic [PW-1:0] fp, rp, tg, pn;
      logic rt;
      fp = 32'h1000 + 4 * ($urandom % 12) + (($urandom % 2) * 32'h10000);
      rp = 32'h1000 + 4 * ($urandom % 12) + (($urandom % 2) * 32'h10000);
      tg = 32'h8000 + 4 * ($urandom % 16);
      rt = 1'($urandom % 3 != 0);
      case ($urandom % 3)
        0: pn = rp + 4;
        1: pn = tg;
        default: pn = 32'h9000 + 4 * ($urandom % 4);
      endcase
      cyc(1'($urandom % 4 != 0), fp, 1'($urandom % 2), rp, rt, tg, pn);
    end

    summary();
    $finish;
  end

endmodule